// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block sits in front of a small word-addressed memory and serves several requesters. Each requester can issue four kinds of access: a plain load, a plain store, a linked load and a conditional store. A linked load returns the addressed word and records a reservation for that requester on that address. A conditional store succeeds only while the requester still holds a reservation on the same address. On success it writes the word and returns 1. On failure it leaves memory untouched and returns 0, so software can loop until an atomic exchange or update goes through.

Each requester has its own reservation: a valid bit and an address. Any write that reaches memory clears every reservation that matches the written address, including the writer's own. Both plain stores and successful conditional stores count as writes. A conditional store always clears the issuing requester's reservation. One access is granted per cycle, and the lowest-numbered requester has priority. The response comes back registered one cycle later on the granted requester's response lane.

Top module: `llsc_monitor`

## Requirements
- R1: Reset clears every memory word to zero, drops all reservations and holds every response valid low; a conditional store issued right after reset returns 0.
- R2: At most one requester is granted per cycle, only a requesting one, and the lowest index wins when several request at once.
- R3: The response for a granted access is valid on that requester's lane exactly one cycle after the grant, and on no other lane.
- R4: A linked load (op code 2) returns the word stored at its address and records a reservation for the issuing requester on that address.
- R5: A conditional store (op code 3) issued while the requester holds a reservation on the same address writes its data and returns 1.
- R6: A conditional store with no reservation, or with a reservation on a different address, returns 0 and leaves memory unchanged.
- R7: A plain store (op code 1) by another requester to a reserved address makes the reserving requester's next conditional store fail.
- R8: A plain store by the reserving requester itself to its reserved address also clears that reservation.
- R9: A conditional store clears the issuer's reservation whether it succeeds or fails, so a second one in a row fails.
- R10: A successful conditional store clears other requesters' reservations on that address; a failed one disturbs no other reservation.
- R11: A write to an address other than the reserved one leaves the reservation intact.
- R12: A new linked load replaces the requester's earlier reservation, so a conditional store to the old address fails.
- R13: A plain load (op code 0) returns the word at its address without any side effect, and a plain store writes its data and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NREQ | Per-requester access request, held until granted |
| op_i | input | NREQ x 2 | Per-requester op: 0 load, 1 store, 2 linked load, 3 conditional store |
| addr_i | input | NREQ x AW | Per-requester word address |
| wdata_i | input | NREQ x DW | Per-requester store data |
| gnt_o | output | NREQ | Combinational grant, one-hot or zero |
| rsp_valid_o | output | NREQ | Registered response valid, one cycle after grant |
| rsp_data_o | output | NREQ x DW | Response word: read data, 1/0 for conditional store, 0 for store |

## Verification
The grant is combinational, so the bench reads it in the same cycle the request is driven, on the falling edge before the capturing clock edge. Every result passes through exactly one register: the response valid, the read data and the 1/0 store outcome all appear after the next rising edge. Memory and reservation effects become visible to any access granted in a later cycle. The bench therefore drives on a falling edge, checks the grant there, waits one rising edge, checks the response on the following falling edge, and only then issues the next access. That access reads back whatever the previous one may have changed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } op_e;
endpackage

// File: rtl/llsc_arb.sv
module llsc_arb #(
  parameter int NREQ = 2,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic [NREQ-1:0] req_i,
  output logic [NREQ-1:0] gnt_o,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  // fixed priority, lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv
  import llsc_pkg::*;
#(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [IW-1:0] idx_i,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output logic          sc_ok_o
);
  logic [NREQ-1:0]         vld_q;
  logic [NREQ-1:0][AW-1:0] adr_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_entry
    logic own, hit;
    assign own = acc_i && (idx_i == IW'(g));
    assign hit = we_i && vld_q[g] && (adr_q[g] == addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        adr_q[g] <= '0;
      end else if (own && op_i == OP_LL) begin
        vld_q[g] <= 1'b1;
        adr_q[g] <= addr_i;
      end else if ((own && op_i == OP_SC) || hit) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign sc_ok_o = vld_q[idx_i] && (adr_q[idx_i] == addr_i);
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NREQ-1:0]         req_i,
  input  logic [NREQ-1:0][1:0]    op_i,
  input  logic [NREQ-1:0][AW-1:0] addr_i,
  input  logic [NREQ-1:0][DW-1:0] wdata_i,
  output logic [NREQ-1:0]         gnt_o,
  output logic [NREQ-1:0]         rsp_valid_o,
  output logic [NREQ-1:0][DW-1:0] rsp_data_o
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [IW-1:0] idx;
  logic          acc;
  op_e           op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata, result;
  logic          sc_ok, we;

  llsc_arb #(.NREQ(NREQ)) i_arb (
    .req_i (req_i),
    .gnt_o (gnt_o),
    .idx_o (idx),
    .any_o (acc)
  );

  assign op    = op_e'(op_i[idx]);
  assign addr  = addr_i[idx];
  assign wdata = wdata_i[idx];
  assign we    = acc && ((op == OP_STORE) || (op == OP_SC && sc_ok));

  llsc_resv #(.NREQ(NREQ), .AW(AW)) i_resv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .idx_i   (idx),
    .op_i    (op),
    .addr_i  (addr),
    .we_i    (we),
    .sc_ok_o (sc_ok)
  );

  llsc_mem #(.AW(AW), .DW(DW)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  always_comb begin
    unique case (op)
      OP_LOAD, OP_LL: result = rdata;
      OP_SC:          result = DW'(sc_ok);
      default:        result = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= gnt_o;
      if (acc) rsp_data_o[idx] <= result;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NREQ = 2,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NREQ-1:0]         req_i,
  input logic [NREQ-1:0][1:0]    op_i,
  input logic [NREQ-1:0][AW-1:0] addr_i,
  input logic [NREQ-1:0][DW-1:0] wdata_i,
  input logic [NREQ-1:0]         gnt_o,
  input logic [NREQ-1:0]         rsp_valid_o,
  input logic [NREQ-1:0][DW-1:0] rsp_data_o
);
  logic [1:0]    gop;
  logic [DW-1:0] rsp_or;

  always_comb begin
    gop    = '0;
    rsp_or = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (gnt_o[i]) gop = op_i[i];
      if (rsp_valid_o[i]) rsp_or = rsp_or | rsp_data_o[i];
    end
  end

  a_r2_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r2_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  a_r2_index0_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |-> gnt_o[0]);
  a_r3_rsp_follows_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> rsp_valid_o == $past(gnt_o));
  a_r3_no_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|gnt_o) |=> rsp_valid_o == '0);
  a_r6_sc_result_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|gnt_o) && gop == 2'd3) |=> rsp_or[DW-1:1] == '0);
  a_r13_store_returns_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|gnt_o) && gop == 2'd1) |=> rsp_or == '0);
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> rsp_valid_o == '0);
endmodule

bind llsc_monitor llsc_monitor_chk #(.NREQ(NREQ), .AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 2;
  localparam int AW = 4;
  localparam int DW = 32;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  typedef struct packed {
    logic       rid;
    logic [1:0] op;
    logic [3:0] addr;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [7:0] rq;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, SC, 4'd3, 32'h55, 32'h0,  8'd1 },  // R1 no reservation after reset
    '{1'b0, LD, 4'd3, 32'h0,  32'h0,  8'd6 },  // R6 memory untouched
    '{1'b0, ST, 4'd3, 32'h11, 32'h0,  8'd13},  // R13 store returns 0
    '{1'b0, LL, 4'd3, 32'h0,  32'h11, 8'd4 },  // R4
    '{1'b0, SC, 4'd3, 32'h22, 32'h1,  8'd5 },  // R5
    '{1'b1, LD, 4'd3, 32'h0,  32'h22, 8'd5 },  // R5 written
    '{1'b0, SC, 4'd3, 32'h33, 32'h0,  8'd9 },  // R9 second SC fails
    '{1'b1, LD, 4'd3, 32'h0,  32'h22, 8'd9 },  // R9 no write
    '{1'b0, LL, 4'd5, 32'h0,  32'h0,  8'd4 },
    '{1'b1, ST, 4'd5, 32'h44, 32'h0,  8'd13},
    '{1'b0, SC, 4'd5, 32'h66, 32'h0,  8'd7 },  // R7
    '{1'b0, LD, 4'd5, 32'h0,  32'h44, 8'd7 },
    '{1'b0, LL, 4'd7, 32'h0,  32'h0,  8'd4 },
    '{1'b0, SC, 4'd8, 32'h9,  32'h0,  8'd6 },  // R6 other address
    '{1'b0, LD, 4'd8, 32'h0,  32'h0,  8'd6 },
    '{1'b0, LL, 4'd2, 32'h0,  32'h0,  8'd4 },
    '{1'b1, ST, 4'd9, 32'h7,  32'h0,  8'd13},
    '{1'b0, SC, 4'd2, 32'h5a, 32'h1,  8'd11},  // R11
    '{1'b0, LL, 4'd4, 32'h0,  32'h0,  8'd4 },
    '{1'b1, LL, 4'd4, 32'h0,  32'h0,  8'd4 },
    '{1'b1, SC, 4'd4, 32'h77, 32'h1,  8'd10},  // R10 success clears others
    '{1'b0, SC, 4'd4, 32'h88, 32'h0,  8'd10},
    '{1'b0, LD, 4'd4, 32'h0,  32'h77, 8'd10},
    '{1'b0, LL, 4'd6, 32'h0,  32'h0,  8'd4 },
    '{1'b1, SC, 4'd6, 32'h1,  32'h0,  8'd10},  // R10 failed SC harmless
    '{1'b0, SC, 4'd6, 32'hab, 32'h1,  8'd10},
    '{1'b0, LL, 4'd1, 32'h0,  32'h0,  8'd4 },
    '{1'b0, ST, 4'd1, 32'h3,  32'h0,  8'd8 },  // R8
    '{1'b0, SC, 4'd1, 32'h4,  32'h0,  8'd8 },
    '{1'b0, LL, 4'd1, 32'h0,  32'h3,  8'd12},  // R12
    '{1'b0, LL, 4'd2, 32'h0,  32'h5a, 8'd12},
    '{1'b0, SC, 4'd1, 32'hc,  32'h0,  8'd12},
    '{1'b0, LD, 4'd1, 32'h0,  32'h3,  8'd12}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [NREQ-1:0]         req;
  logic [NREQ-1:0][1:0]    op;
  logic [NREQ-1:0][AW-1:0] addr;
  logic [NREQ-1:0][DW-1:0] wdata;
  logic [NREQ-1:0]         gnt;
  logic [NREQ-1:0]         rsp_valid;
  logic [NREQ-1:0][DW-1:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  llsc_monitor #(.NREQ(NREQ), .AW(AW), .DW(DW)) i_llsc_monitor (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .op_i        (op),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .gnt_o       (gnt),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int rid, input logic [1:0] o, input logic [3:0] a,
                       input logic [31:0] d, input logic [31:0] ex, input int rq);
    string t;
    t = $sformatf("R%0d", rq);
    @(negedge clk);
    req = '0;
    req[rid] = 1'b1;
    op[rid] = o;
    addr[rid] = a;
    wdata[rid] = d;
    #1;
    check("R2 grant", DW'(gnt), DW'(1 << rid));
    @(negedge clk);
    req = '0;
    check("R3 rsp valid", DW'(rsp_valid), DW'(1 << rid));
    check(t, rsp_data[rid], ex);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    req = '0; op = '0; addr = '0; wdata = '0;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 rsp idle", DW'(rsp_valid), '0);
    check("R1 no grant", DW'(gnt), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      do_op(int'(VECS[v].rid), VECS[v].op, VECS[v].addr, VECS[v].wd, VECS[v].ex, int'(VECS[v].rq));

    // R2 contention: both request, index 0 first, index 1 held
    @(negedge clk);
    req = 2'b11;
    op[0] = LD; addr[0] = 4'd3;
    op[1] = LD; addr[1] = 4'd4;
    #1;
    check("R2 priority", DW'(gnt), 32'h1);
    @(negedge clk);
    req[0] = 1'b0;
    check("R3 lane0 valid", DW'(rsp_valid), 32'h1);
    check("R3 lane0 data", rsp_data[0], 32'h22);
    #1;
    check("R2 second grant", DW'(gnt), 32'h2);
    @(negedge clk);
    req = '0;
    check("R3 lane1 valid", DW'(rsp_valid), 32'h2);
    check("R3 lane1 data", rsp_data[1], 32'h77);

    // R1 reset mid-run drops reservation and clears memory
    do_op(0, LL, 4'd3, 32'h0, 32'h22, 4);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rsp idle in reset", DW'(rsp_valid), '0);
    rst_n = 1'b1;
    do_op(0, SC, 4'd3, 32'h99, 32'h0, 1);
    do_op(1, LD, 4'd3, 32'h0, 32'h0, 1);

    // R13 load has no side effect on a reservation
    do_op(0, LL, 4'd6, 32'h0, 32'h0, 4);
    do_op(1, LD, 4'd6, 32'h0, 32'h0, 13);
    do_op(0, SC, 4'd6, 32'h5, 32'h1, 13);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule